// File: doc/BRIEF.md
# Programmable-Priority Pending Resolver

This block picks the highest-priority active interrupt source, and it does so separately for the fast class and the normal class. The priority order comes from a table that software writes. Each table entry names one source by ID, so the order is not fixed by source number. The source state arrives as two 32-bit banks for each of three properties: pending, enable, and class steering. Sources 0 to 31 live in the low bank and sources 32 and up live in the high bank.

The block scans the table. Entries at lower indices take precedence. For each class it reports the first entry whose source is active and belongs to that class. Both winners are packed into one 32-bit word: the fast-class result sits in the low half and the normal-class result in the high half. The word is computed combinationally from the inputs and registered on every clock edge, so it lags its inputs by one cycle. The table storage and any register bus sit outside this block.

Top module: `prio_resolver`

## Requirements
- R1: While reset is high and on the cycle after it, `result` reads 0x003F003F. The same value follows any cycle in which no entry qualifies for either class.
- R2: A table entry takes part only if its valid bit is set and its ID is below 40. Entry i occupies `prio_tbl[7*i+6 : 7*i]`, with bit 6 as the valid bit and bits 5:0 as the ID. Any other entry has no effect on `result`.
- R3: A source is active when both its pending bit and its enable bit are set. IDs 0 to 31 use bit ID of the `_lo` banks. IDs 32 to 39 use bit ID-32 of the `_hi` banks.
- R4: An active source whose steering bit is 1 is a fast-class candidate. The fast-class winner sets `result[15]` and places its ID in `result[5:0]`.
- R5: An active source whose steering bit is 0 is a normal-class candidate. The normal-class winner sets `result[31]` and places its ID in `result[21:16]`.
- R6: In each class, the winner is the qualifying entry with the smallest table index.
- R7: The two classes resolve independently. A winner in one class never changes the other half of the word.
- R8: Bits 30:22 and 14:6 always read 0. A half with no winner has its valid bit at 0 and its ID field at 0x3F.
- R9: When several entries carry the same ID, the smallest-index entry decides the result, and the reported ID is always that source's ID.
- R10: `result` after a clock edge equals the resolution of the inputs present at that edge. The latency is exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_lo | input | 32 | Pending bits, sources 0-31 |
| pend_hi | input | 32 | Pending bits, sources 32 and up |
| en_lo | input | 32 | Enable bits, sources 0-31 |
| en_hi | input | 32 | Enable bits, sources 32 and up |
| fast_lo | input | 32 | Class steering, 1 = fast class, sources 0-31 |
| fast_hi | input | 32 | Class steering, sources 32 and up |
| prio_tbl | input | 280 | 40 priority entries, 7 bits each (valid, 6-bit ID) |
| result | output | 32 | Registered winner word (normal class high, fast class low) |

## Verification
The checker covers the properties that hold on every cycle. These are the reset value, the zero reserved bits, the 0x3F marker in any half without a winner, the ID range of a reported winner, and the fact that a reported winner was active and in the right class one cycle earlier. Only the bench scenarios can show that the *right* entry won. That covers lowest-index precedence, duplicate IDs, the choice of bank for IDs at 32 and above, entries rejected by the valid bit or the ID range, and whether one class leaves the other undisturbed. The bench checks these against a behavioural model on every clock.

// File: rtl/prs_pkg.sv
package prs_pkg;

    localparam int BANK_W  = 32;
    localparam int ID_W    = 6;
    localparam int ENTRY_W = ID_W + 1;
    localparam int SPAN    = 1 << ID_W;
    localparam int RSV_W   = 16 - ID_W - 1;

    localparam logic [ID_W-1:0] NO_ID = '1;

    typedef enum logic {
        CLS_FAST   = 1'b0,
        CLS_NORMAL = 1'b1
    } class_e;

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
    } prio_entry_t;

    typedef struct packed {
        logic            found;
        logic [ID_W-1:0] id;
    } pick_t;

    typedef struct packed {
        logic             nrm_vld;
        logic [RSV_W-1:0] rsv_hi;
        logic [ID_W-1:0]  nrm_id;
        logic             fst_vld;
        logic [RSV_W-1:0] rsv_lo;
        logic [ID_W-1:0]  fst_id;
    } result_t;

    localparam result_t IDLE_WORD = '{
        nrm_vld: 1'b0, rsv_hi: '0, nrm_id: NO_ID,
        fst_vld: 1'b0, rsv_lo: '0, fst_id: NO_ID
    };

    function automatic result_t pack_result(pick_t fst, pick_t nrm);
        result_t r;
        r = IDLE_WORD;
        if (fst.found) begin
            r.fst_vld = 1'b1;
            r.fst_id  = fst.id;
        end
        if (nrm.found) begin
            r.nrm_vld = 1'b1;
            r.nrm_id  = nrm.id;
        end
        return r;
    endfunction

endpackage

// File: rtl/prs_src_qual.sv
module prs_src_qual
    import prs_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic [BANK_W-1:0]  pend_lo,
    input  logic [BANK_W-1:0]  pend_hi,
    input  logic [BANK_W-1:0]  en_lo,
    input  logic [BANK_W-1:0]  en_hi,
    input  logic [BANK_W-1:0]  fast_lo,
    input  logic [BANK_W-1:0]  fast_hi,
    output logic [NUM_SRC-1:0] fast_act,
    output logic [NUM_SRC-1:0] nrm_act
);
    localparam int ALL_W = 2 * BANK_W;

    logic [ALL_W-1:0] pend_all;
    logic [ALL_W-1:0] en_all;
    logic [ALL_W-1:0] fast_all;

    assign pend_all = {pend_hi, pend_lo};
    assign en_all   = {en_hi, en_lo};
    assign fast_all = {fast_hi, fast_lo};

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic live;
        assign live        = pend_all[s] & en_all[s];
        assign fast_act[s] = live & fast_all[s];
        assign nrm_act[s]  = live & ~fast_all[s];
    end

    if (ALL_W > NUM_SRC) begin : g_unused
        logic unused_bits;
        assign unused_bits = ^{pend_all[ALL_W-1:NUM_SRC],
                               en_all[ALL_W-1:NUM_SRC],
                               fast_all[ALL_W-1:NUM_SRC]};
    end
endmodule

// File: rtl/prs_entry_eval.sv
module prs_entry_eval
    import prs_pkg::*;
#(
    parameter int NUM_ENTRIES = 40,
    parameter int NUM_SRC     = 40
) (
    input  logic [NUM_ENTRIES*ENTRY_W-1:0]   prio_tbl,
    input  logic [NUM_SRC-1:0]               fast_act,
    input  logic [NUM_SRC-1:0]               nrm_act,
    output logic [NUM_ENTRIES-1:0]           fast_cand,
    output logic [NUM_ENTRIES-1:0]           nrm_cand,
    output logic [NUM_ENTRIES-1:0][ID_W-1:0] ent_id
);
    localparam logic [ID_W:0] SRC_LIM = (ID_W+1)'(NUM_SRC);

    logic [SPAN-1:0] fast_pad;
    logic [SPAN-1:0] nrm_pad;

    assign fast_pad = SPAN'(fast_act);
    assign nrm_pad  = SPAN'(nrm_act);

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        prio_entry_t ent;
        logic        usable;
        assign ent          = prio_entry_t'(prio_tbl[e*ENTRY_W +: ENTRY_W]);
        assign usable       = ent.valid && ({1'b0, ent.id} < SRC_LIM);
        assign fast_cand[e] = usable & fast_pad[ent.id];
        assign nrm_cand[e]  = usable & nrm_pad[ent.id];
        assign ent_id[e]    = ent.id;
    end
endmodule

// File: rtl/prs_class_pick.sv
module prs_class_pick
    import prs_pkg::*;
#(
    parameter int NUM_ENTRIES = 40
) (
    input  logic [NUM_ENTRIES-1:0]           cand,
    input  logic [NUM_ENTRIES-1:0][ID_W-1:0] ent_id,
    output pick_t                            pick
);
    always_comb begin
        pick = '{found: 1'b0, id: NO_ID};
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (cand[i]) begin
                pick.found = 1'b1;
                pick.id    = ent_id[i];
            end
        end
    end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
    import prs_pkg::*;
#(
    parameter int NUM_ENTRIES = 40,
    parameter int NUM_SRC     = 40
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [31:0]                    pend_lo,
    input  logic [31:0]                    pend_hi,
    input  logic [31:0]                    en_lo,
    input  logic [31:0]                    en_hi,
    input  logic [31:0]                    fast_lo,
    input  logic [31:0]                    fast_hi,
    input  logic [NUM_ENTRIES*ENTRY_W-1:0] prio_tbl,
    output logic [31:0]                    result
);
    localparam int NUM_CLS = 2;

    logic [NUM_SRC-1:0]               fast_act;
    logic [NUM_SRC-1:0]               nrm_act;
    logic [NUM_ENTRIES-1:0]           fast_cand;
    logic [NUM_ENTRIES-1:0]           nrm_cand;
    logic [NUM_ENTRIES-1:0][ID_W-1:0] ent_id;
    logic [NUM_CLS-1:0][NUM_ENTRIES-1:0] cls_cand;
    pick_t                            cls_pick [NUM_CLS];
    result_t                          res_d;
    result_t                          res_q;

    prs_src_qual #(.NUM_SRC(NUM_SRC)) u_qual (
        .pend_lo  (pend_lo),
        .pend_hi  (pend_hi),
        .en_lo    (en_lo),
        .en_hi    (en_hi),
        .fast_lo  (fast_lo),
        .fast_hi  (fast_hi),
        .fast_act (fast_act),
        .nrm_act  (nrm_act)
    );

    prs_entry_eval #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_SRC(NUM_SRC)) u_eval (
        .prio_tbl  (prio_tbl),
        .fast_act  (fast_act),
        .nrm_act   (nrm_act),
        .fast_cand (fast_cand),
        .nrm_cand  (nrm_cand),
        .ent_id    (ent_id)
    );

    assign cls_cand[CLS_FAST]   = fast_cand;
    assign cls_cand[CLS_NORMAL] = nrm_cand;

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        prs_class_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
            .cand   (cls_cand[c]),
            .ent_id (ent_id),
            .pick   (cls_pick[c])
        );
    end

    assign res_d = pack_result(cls_pick[CLS_FAST], cls_pick[CLS_NORMAL]);

    always_ff @(posedge clk) begin
        if (rst) res_q <= IDLE_WORD;
        else     res_q <= res_d;
    end

    assign result = res_q;
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk
    import prs_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pend_lo,
    input logic [31:0] pend_hi,
    input logic [31:0] en_lo,
    input logic [31:0] en_hi,
    input logic [31:0] fast_lo,
    input logic [31:0] fast_hi,
    input logic [31:0] result
);
    logic [63:0] fast_seen_q;
    logic [63:0] nrm_seen_q;
    logic [63:0] live_now;

    assign live_now = {pend_hi, pend_lo} & {en_hi, en_lo};

    always_ff @(posedge clk) begin
        fast_seen_q <= live_now & {fast_hi, fast_lo};
        nrm_seen_q  <= live_now & ~{fast_hi, fast_lo};
    end

    a_r1_reset_value: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> result == 32'h003F003F);

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        result[30:22] == 9'd0 && result[14:6] == 9'd0);

    a_r8_idle_fast_half: assert property (@(posedge clk) disable iff (rst)
        !result[15] |-> result[5:0] == 6'h3F);

    a_r8_idle_normal_half: assert property (@(posedge clk) disable iff (rst)
        !result[31] |-> result[21:16] == 6'h3F);

    a_r2_fast_id_range: assert property (@(posedge clk) disable iff (rst)
        result[15] |-> 32'(result[5:0]) < NUM_SRC);

    a_r2_normal_id_range: assert property (@(posedge clk) disable iff (rst)
        result[31] |-> 32'(result[21:16]) < NUM_SRC);

    a_r4_fast_winner_live: assert property (@(posedge clk) disable iff (rst)
        result[15] |-> fast_seen_q[result[5:0]]);

    a_r5_normal_winner_live: assert property (@(posedge clk) disable iff (rst)
        result[31] |-> nrm_seen_q[result[21:16]]);
endmodule

bind prio_resolver prio_resolver_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pend_lo (pend_lo),
    .pend_hi (pend_hi),
    .en_lo   (en_lo),
    .en_hi   (en_hi),
    .fast_lo (fast_lo),
    .fast_hi (fast_hi),
    .result  (result)
);

// File: tb/prio_resolver_tb.sv
`timescale 1ns/1ps
module prio_resolver_tb;
    localparam int NE = 40;
    localparam int NS = 40;
    localparam logic [31:0] IDLE = 32'h003F003F;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [31:0]   pend_lo = '0, pend_hi = '0, en_lo = '0, en_hi = '0;
    logic [31:0]   fast_lo = '0, fast_hi = '0;
    logic [NE*7-1:0] prio_tbl = '0;
    logic [31:0]   result;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_q;
    bit   armed = 1'b0;
    bit   done  = 1'b0;

    always #2.5 clk = ~clk;

    prio_resolver u_dut (
        .clk(clk), .rst(rst),
        .pend_lo(pend_lo), .pend_hi(pend_hi),
        .en_lo(en_lo), .en_hi(en_hi),
        .fast_lo(fast_lo), .fast_hi(fast_hi),
        .prio_tbl(prio_tbl), .result(result)
    );

    // Behavioural model: walk the table from index 0, first hit per class wins.
    function automatic logic [31:0] model();
        logic [63:0] p, e, f;
        int  fid, nid;
        bit  fdone, ndone;
        p = {pend_hi, pend_lo};
        e = {en_hi, en_lo};
        f = {fast_hi, fast_lo};
        fdone = 0; ndone = 0; fid = 0; nid = 0;
        for (int i = 0; i < NE; i++) begin
            int id;
            id = int'(prio_tbl[i*7 +: 6]);
            if (prio_tbl[i*7+6] && id < NS && p[id] && e[id]) begin
                if (f[id] && !fdone) begin fdone = 1; fid = id; end
                if (!f[id] && !ndone) begin ndone = 1; nid = id; end
            end
        end
        model = IDLE;
        if (fdone) model[15:0]  = 16'h8000 | 16'(fid);
        if (ndone) model[31:16] = 16'h8000 | 16'(nid);
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: result=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_ent(input int i, input bit v, input int id);
        prio_tbl[i*7 +: 7] = {v, 6'(id)};
    endtask

    task automatic clear_all();
        prio_tbl = '0;
        pend_lo = '0; pend_hi = '0; en_lo = '0; en_hi = '0;
        fast_lo = '0; fast_hi = '0;
    endtask

    // Apply the current inputs, let one edge register them, check at negedge.
    task automatic run_check(input logic [31:0] exp, input string tag);
        @(posedge clk);
        @(negedge clk);
        check(result, exp, tag);
        check(result, model(), tag);
    endtask

    // Per-cycle comparison against the model (R10: one-cycle latency).
    always @(posedge clk) begin
        exp_q <= rst ? IDLE : model();
        armed <= 1'b1;
    end
    always @(negedge clk) if (armed && !done) check(result, exp_q, "R10");

    initial begin
        #(200000 * 5);
        n_checks++; n_fail++;
        $display("FAIL watchdog: result=%h expected=completion", result);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(result, IDLE, "R1 reset");
        pend_lo = '1; en_lo = '1;
        @(posedge clk); @(negedge clk);
        check(result, IDLE, "R1 held in reset");
        rst = 1'b0;

        // R1/R2: nothing in the table qualifies
        run_check(IDLE, "R1 R2 empty table");

        // R5/R3: single normal-class source in low bank
        clear_all();
        set_ent(5, 1, 3); pend_lo[3] = 1; en_lo[3] = 1;
        run_check(32'h8003003F, "R5 R3 normal id 3");

        // R4: same source steered to fast class
        fast_lo[3] = 1;
        run_check(32'h003F8003, "R4 fast id 3");

        // R2: ID out of range and valid bit clear are ignored
        clear_all();
        pend_lo = '1; en_lo = '1; pend_hi = '1; en_hi = '1;
        set_ent(0, 1, 45); set_ent(1, 0, 7);
        run_check(IDLE, "R2 rejected entries");
        set_ent(2, 1, 39);
        run_check(32'h8027003F, "R2 id 39 accepted");

        // R3: ID 35 uses bit 3 of the high banks only
        clear_all();
        set_ent(0, 1, 35); pend_lo[3] = 1; en_lo[3] = 1;
        run_check(IDLE, "R3 low bank does not serve id 35");
        pend_hi[3] = 1; en_hi[3] = 1; fast_hi[3] = 1;
        run_check(32'h003F8023, "R3 high bank id 35");
        en_hi[3] = 0;
        run_check(IDLE, "R3 pending without enable");

        // R6: smallest index wins, not smallest ID
        clear_all();
        set_ent(2, 1, 10); set_ent(7, 1, 4);
        pend_lo = 32'h0000_0410; en_lo = '1;
        run_check(32'h800A003F, "R6 index 2 over index 7");
        set_ent(2, 0, 10);
        run_check(32'h8004003F, "R6 fallback to index 7");

        // R7: both classes resolved independently
        clear_all();
        set_ent(0, 1, 1); set_ent(1, 1, 2); set_ent(3, 1, 6);
        pend_lo = 32'h46; en_lo = '1; fast_lo = 32'h02;
        run_check(32'h80028001, "R7 both halves");
        fast_lo = 32'h46;
        run_check(32'h003F8001, "R7 normal half idle");

        // R9: duplicate IDs
        clear_all();
        set_ent(1, 1, 9); set_ent(3, 1, 9); set_ent(0, 1, 12); set_ent(4, 1, 20);
        pend_lo = 32'h0010_0200; en_lo = '1;
        run_check(32'h8009003F, "R9 duplicate id 9");
        fast_lo[9] = 1;
        run_check(32'h80148009, "R9 duplicate steered fast");

        // Random traffic, R8 on each sample
        for (int k = 0; k < 400; k++) begin
            pend_lo = $urandom; pend_hi = $urandom;
            en_lo = $urandom; en_hi = $urandom;
            fast_lo = $urandom; fast_hi = $urandom;
            for (int i = 0; i < NE; i++)
                set_ent(i, ($urandom % 4) != 0, $urandom % 48);
            @(posedge clk); @(negedge clk);
            check({result[30:22], result[14:6]}, 18'd0, "R8 reserved bits");
            check(result, model(), "R6 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule